// File: doc/BRIEF.md
# Sample-Ready Interrupt and Status Logic

This block sits between a sensor's acquisition engine and its serial register interface. Every time the engine produces a sample, it pulses a strobe. That strobe raises an acquisition flag in a status register. Software can poll the flag at any time. If the matching enable bit is set, the flag also drives an external interrupt pin. Reading the status register returns the flag and clears it, which rearms it for the next sample.

A mode register sets the pin's active polarity. It also selects whether the pin is driven push-pull or open-drain. The block also controls when a new sample is copied into the readable data registers. A new sample is taken only if the bus has seen at least one STOP condition since the last copy. Otherwise the old values are held, so a multi-byte read that is still in progress stays coherent.

Register accesses arrive as single-cycle read and write strobes with an address and a byte of write data. Read data appears on `regRdata` one cycle after the read strobe.

Top module: `acq_irq_status`

## Requirements
- R1: A pulse on `sampleStb` sets the acquisition flag (bit 0 of the status register, address 0x3) from the next cycle. Two samples with no read between them leave one set flag, and a single status read clears it.
- R2: The flag sets on a sample even when the enable bit is 0. In that case the pin stays at its inactive level.
- R3: The interrupt is active exactly while the flag is set and bit 0 of the enable register (address 0x6) is 1. Clearing the enable bit while the flag is set returns the pin to inactive, and setting it again reasserts the pin.
- R4: A read strobe at address 0x3 places the flag's value from before the clear on `regRdata[0]` in the following cycle, with the other bits 0. The same strobe clears the flag and so deasserts the interrupt.
- R5: Bit 1 of the mode register (address 0x7) selects the active level: 1 is active-high, 0 is active-low. With bit 0 of the mode register at 0 (push-pull), `pinOe` is always 1 and `pinOut` is the active level while the interrupt is active and the opposite level otherwise.
- R6: With bit 0 of the mode register at 1 (open-drain), `pinOut` always carries the active level. `pinOe` is 1 only while the interrupt is active.
- R7: On a sample strobe, `dataOut` loads `sampleData` only if a `stopSeen` pulse occurred after the previous load. A STOP in the same cycle as the strobe counts. The first sample after reset always loads. In every other case `dataOut` holds its value.
- R8: If a sample strobe and a status read fall in the same cycle, the read returns the old flag value and the flag remains set afterwards.
- R9: After reset, the flag, `dataOut`, and the enable and mode registers are all 0. The pin is therefore push-pull active-low at its inactive level: `pinOut`=1 and `pinOe`=1.
- R10: The enable and mode registers read back the full byte last written to them. A read of any unmapped address returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| sampleStb | input | 1 | One-cycle pulse: a new sample is ready |
| sampleData | input | AXES*AXIS_W | New sample, all axes packed, axis 0 in the low bits |
| stopSeen | input | 1 | One-cycle pulse: a bus STOP condition was detected |
| regWr | input | 1 | Register write strobe |
| regRd | input | 1 | Register read strobe |
| regAddr | input | ADDR_W | Register address |
| regWdata | input | 8 | Register write data |
| regRdata | output | 8 | Register read data, valid the cycle after `regRd` |
| dataOut | output | AXES*AXIS_W | Readable sample data registers |
| pinOut | output | 1 | Interrupt pin data value |
| pinOe | output | 1 | Interrupt pin output enable |

## Verification
The bench targets the following corner cases and the failure each one exposes:
- A sample strobe and a status read in the same cycle. A design that gives the clear priority would drop that sample's event: the next read would return 0 and the pin would fall.
- A sample with no STOP since the previous update. A design without gating would overwrite `dataOut` mid-transfer.
- A STOP in the same cycle as the sample. A design that only counts earlier STOPs would fail to refresh.
- All four pin configurations, including enabling and disabling interrupts while the flag is already set. Swapped polarity or drive logic shows up as a wrong `pinOut`/`pinOe` pair at idle or at the active level.

// File: rtl/acq_irq_pkg.sv
package acq_irq_pkg;

  typedef enum logic [1:0] {
    SEL_NONE,
    SEL_STATUS,
    SEL_ENABLE,
    SEL_MODE
  } rdSel_e;

  typedef struct packed {
    logic       statusRd;
    logic       enableWr;
    logic       modeWr;
    logic       rdStb;
    rdSel_e     rdSel;
    logic [7:0] wrData;
  } ctrlStb_t;

  localparam int STAT_ACQ_BIT = 0;
  localparam int EN_ACQ_BIT   = 0;
  localparam int MODE_OD_BIT  = 0;
  localparam int MODE_AH_BIT  = 1;

endpackage

// File: rtl/acq_irq_ctrl.sv
module acq_irq_ctrl
  import acq_irq_pkg::*;
#(
  parameter int                ADDR_W      = 4,
  parameter logic [ADDR_W-1:0] STATUS_ADDR = ADDR_W'(3),
  parameter logic [ADDR_W-1:0] ENABLE_ADDR = ADDR_W'(6),
  parameter logic [ADDR_W-1:0] MODE_ADDR   = ADDR_W'(7)
) (
  input  logic              regWr,
  input  logic              regRd,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [7:0]        regWdata,
  output ctrlStb_t          strb
);

  logic hitStatus, hitEnable, hitMode;

  assign hitStatus = (regAddr == STATUS_ADDR);
  assign hitEnable = (regAddr == ENABLE_ADDR);
  assign hitMode   = (regAddr == MODE_ADDR);

  always_comb begin
    strb          = '0;
    strb.wrData   = regWdata;
    strb.rdStb    = regRd;
    strb.statusRd = regRd && hitStatus;
    strb.enableWr = regWr && hitEnable;
    strb.modeWr   = regWr && hitMode;
    if (hitStatus)      strb.rdSel = SEL_STATUS;
    else if (hitEnable) strb.rdSel = SEL_ENABLE;
    else if (hitMode)   strb.rdSel = SEL_MODE;
    else                strb.rdSel = SEL_NONE;
  end

endmodule

// File: rtl/acq_irq_pin.sv
module acq_irq_pin (
  input  logic irqActive,
  input  logic openDrain,
  input  logic activeHigh,
  output logic pinOut,
  output logic pinOe
);

  always_comb begin
    if (openDrain) begin
      pinOut = activeHigh;
      pinOe  = irqActive;
    end else begin
      pinOut = irqActive ? activeHigh : !activeHigh;
      pinOe  = 1'b1;
    end
  end

endmodule

// File: rtl/acq_irq_dp.sv
module acq_irq_dp
  import acq_irq_pkg::*;
#(
  parameter  int AXES     = 3,
  parameter  int AXIS_W   = 16,
  localparam int SAMPLE_W = AXES * AXIS_W
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctrlStb_t            strb,
  input  logic                sampleStb,
  input  logic [SAMPLE_W-1:0] sampleData,
  input  logic                stopSeen,
  output logic [7:0]          regRdata,
  output logic [SAMPLE_W-1:0] dataOut,
  output logic                irqActive,
  output logic                openDrain,
  output logic                activeHigh
);

  logic       acqFlag;
  logic       stopPend;
  logic       loadData;
  logic [7:0] enReg, modeReg, rdReg, rdMux;
  logic [AXIS_W-1:0] axisReg [AXES];

  assign loadData = sampleStb && (stopPend || stopSeen);

  always_ff @(posedge clk) begin
    if (!rstN)              acqFlag <= 1'b0;
    else if (sampleStb)     acqFlag <= 1'b1;
    else if (strb.statusRd) acqFlag <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rstN)         stopPend <= 1'b1;
    else if (loadData) stopPend <= 1'b0;
    else if (stopSeen) stopPend <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enReg   <= '0;
      modeReg <= '0;
    end else begin
      if (strb.enableWr) enReg   <= strb.wrData;
      if (strb.modeWr)   modeReg <= strb.wrData;
    end
  end

  always_comb begin
    rdMux = '0;
    case (strb.rdSel)
      SEL_STATUS: rdMux[STAT_ACQ_BIT] = acqFlag;
      SEL_ENABLE: rdMux = enReg;
      SEL_MODE:   rdMux = modeReg;
      default:    rdMux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN)           rdReg <= '0;
    else if (strb.rdStb) rdReg <= rdMux;
  end

  for (genvar a = 0; a < AXES; a++) begin : g_axis
    always_ff @(posedge clk) begin
      if (!rstN)         axisReg[a] <= '0;
      else if (loadData) axisReg[a] <= sampleData[a*AXIS_W +: AXIS_W];
    end
    assign dataOut[a*AXIS_W +: AXIS_W] = axisReg[a];
  end

  assign regRdata   = rdReg;
  assign irqActive  = acqFlag && enReg[EN_ACQ_BIT];
  assign openDrain  = modeReg[MODE_OD_BIT];
  assign activeHigh = modeReg[MODE_AH_BIT];

  // R1
  flag_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    sampleStb |=> acqFlag);

  // R4
  rd_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.statusRd && !sampleStb) |=> !acqFlag);

  // R8
  collide_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.statusRd && sampleStb && acqFlag) |=> (acqFlag && regRdata[STAT_ACQ_BIT]));

  // R7
  data_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!sampleStb || (!stopPend && !stopSeen)) |=> $stable(dataOut));

endmodule

// File: rtl/acq_irq_status.sv
module acq_irq_status
  import acq_irq_pkg::*;
#(
  parameter  int                ADDR_W      = 4,
  parameter  int                AXES        = 3,
  parameter  int                AXIS_W      = 16,
  parameter  logic [ADDR_W-1:0] STATUS_ADDR = ADDR_W'(3),
  parameter  logic [ADDR_W-1:0] ENABLE_ADDR = ADDR_W'(6),
  parameter  logic [ADDR_W-1:0] MODE_ADDR   = ADDR_W'(7),
  localparam int                SAMPLE_W    = AXES * AXIS_W
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                sampleStb,
  input  logic [SAMPLE_W-1:0] sampleData,
  input  logic                stopSeen,
  input  logic                regWr,
  input  logic                regRd,
  input  logic [ADDR_W-1:0]   regAddr,
  input  logic [7:0]          regWdata,
  output logic [7:0]          regRdata,
  output logic [SAMPLE_W-1:0] dataOut,
  output logic                pinOut,
  output logic                pinOe
);

  ctrlStb_t strb;
  logic irqActive, openDrain, activeHigh;

  acq_irq_ctrl #(
    .ADDR_W(ADDR_W), .STATUS_ADDR(STATUS_ADDR),
    .ENABLE_ADDR(ENABLE_ADDR), .MODE_ADDR(MODE_ADDR)
  ) u_ctrl (
    .regWr(regWr), .regRd(regRd), .regAddr(regAddr),
    .regWdata(regWdata), .strb(strb)
  );

  acq_irq_dp #(.AXES(AXES), .AXIS_W(AXIS_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .sampleStb(sampleStb),
    .sampleData(sampleData), .stopSeen(stopSeen), .regRdata(regRdata),
    .dataOut(dataOut), .irqActive(irqActive), .openDrain(openDrain),
    .activeHigh(activeHigh)
  );

  acq_irq_pin u_pin (
    .irqActive(irqActive), .openDrain(openDrain), .activeHigh(activeHigh),
    .pinOut(pinOut), .pinOe(pinOe)
  );

endmodule

// File: tb/acq_irq_status_tb.sv
module acq_irq_status_tb;

  localparam int CLK_PERIOD = 10;
  localparam int SW = 48;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sampleStb = 1'b0, stopSeen = 1'b0, regWr = 1'b0, regRd = 1'b0;
  logic [SW-1:0] sampleData = '0;
  logic [3:0] regAddr = '0;
  logic [7:0] regWdata = '0, regRdata;
  logic [SW-1:0] dataOut;
  logic pinOut, pinOe;

  always #(CLK_PERIOD/2) clk = ~clk;

  acq_irq_status u_dut (
    .clk(clk), .rstN(rstN), .sampleStb(sampleStb), .sampleData(sampleData),
    .stopSeen(stopSeen), .regWr(regWr), .regRd(regRd), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .dataOut(dataOut),
    .pinOut(pinOut), .pinOe(pinOe)
  );

  typedef struct {
    int          kind;
    logic [63:0] exp;
    string       req;
  } item_t;

  item_t sb[$];
  int vectors = 0;
  int miscompares = 0;
  bit done = 0;

  localparam int K_PIN = 0, K_RD = 1, K_DATA = 2;

  task automatic push(input int k, input logic [63:0] e, input string r);
    item_t it;
    it.kind = k; it.exp = e; it.req = r;
    sb.push_back(it);
  endtask

  // One access cycle; on return the results of that cycle are visible until the next negedge.
  task automatic op(input bit smp, input logic [SW-1:0] d, input bit stp,
                    input bit rd, input bit wr, input logic [3:0] a, input logic [7:0] wd);
    @(posedge clk); #1;
    sampleStb = smp; sampleData = d; stopSeen = stp;
    regRd = rd; regWr = wr; regAddr = a; regWdata = wd;
    @(posedge clk); #1;
    sampleStb = 0; stopSeen = 0; regRd = 0; regWr = 0;
  endtask

  task automatic sample(input logic [SW-1:0] d, input bit stp);
    op(1, d, stp, 0, 0, 4'h0, 8'h00);
  endtask
  task automatic rdReg(input logic [3:0] a);
    op(0, '0, 0, 1, 0, a, 8'h00);
  endtask
  task automatic wrReg(input logic [3:0] a, input logic [7:0] wd);
    op(0, '0, 0, 0, 1, a, wd);
  endtask

  always @(negedge clk) begin
    while (sb.size() > 0) begin
      item_t it;
      logic [63:0] act;
      it = sb.pop_front();
      case (it.kind)
        K_PIN:   act = {62'd0, pinOut, pinOe};
        K_RD:    act = {56'd0, regRdata};
        default: act = {16'd0, dataOut};
      endcase
      vectors++;
      if (act !== it.exp) begin
        miscompares++;
        $display("FAIL %s kind=%0d actual=%h expected=%h", it.req, it.kind, act, it.exp);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      vectors++; miscompares++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  localparam logic [3:0] A_ST = 4'h3, A_EN = 4'h6, A_MD = 4'h7;
  localparam logic [SW-1:0] DA = 48'h1111_2222_3333, DB = 48'h4444_5555_6666,
                            DC = 48'h7777_8888_9999, DD = 48'hAAAA_BBBB_CCCC,
                            DE = 48'hDDDD_EEEE_FFFF;

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    // R9 reset state
    push(K_PIN, 2'b11, "R9 idle pin"); push(K_DATA, 0, "R9 data");
    rdReg(A_ST); push(K_RD, 0, "R9 flag");
    rdReg(A_EN); push(K_RD, 0, "R9 enable");
    rdReg(A_MD); push(K_RD, 0, "R9 mode");

    // R2 flag without enable, R7 first sample loads
    sample(DA, 0); push(K_DATA, DA, "R7 first load"); push(K_PIN, 2'b11, "R2 pin off");
    rdReg(A_ST); push(K_RD, 1, "R2 flag set"); push(K_PIN, 2'b11, "R2 pin off");
    rdReg(A_ST); push(K_RD, 0, "R4 cleared");

    // R3 enabled active-low push-pull, R7 hold without STOP
    wrReg(A_EN, 8'h01); push(K_PIN, 2'b11, "R3 no flag");
    sample(DB, 0); push(K_DATA, DA, "R7 hold"); push(K_PIN, 2'b01, "R3 active");
    rdReg(A_ST); push(K_RD, 1, "R4 old value"); push(K_PIN, 2'b11, "R4 deassert");

    // R7 STOP between samples
    op(0, '0, 1, 0, 0, 4'h0, 8'h00);
    sample(DC, 0); push(K_DATA, DC, "R7 refresh"); push(K_PIN, 2'b01, "R3 active");
    wrReg(A_EN, 8'h00); push(K_PIN, 2'b11, "R3 disabled");
    wrReg(A_EN, 8'h01); push(K_PIN, 2'b01, "R3 re-enabled");

    // R8 collision
    op(1, DD, 0, 1, 0, A_ST, 8'h00);
    push(K_RD, 1, "R8 read value"); push(K_PIN, 2'b01, "R8 pin kept");
    push(K_DATA, DC, "R7 hold on collision");
    rdReg(A_ST); push(K_RD, 1, "R8 flag kept"); push(K_PIN, 2'b11, "R4 deassert");

    // R5 active-high push-pull, R7 STOP same cycle
    wrReg(A_MD, 8'h02); push(K_PIN, 2'b01, "R5 idle low");
    sample(DE, 1); push(K_DATA, DE, "R7 same-cycle stop"); push(K_PIN, 2'b11, "R5 active high");
    rdReg(A_ST); push(K_PIN, 2'b01, "R5 idle low");

    // R6 open-drain both polarities
    wrReg(A_MD, 8'h01); push(K_PIN, 2'b00, "R6 od low idle");
    sample(DA, 0); push(K_PIN, 2'b01, "R6 od low active");
    wrReg(A_MD, 8'h03); push(K_PIN, 2'b11, "R6 od high active");
    rdReg(A_ST); push(K_PIN, 2'b10, "R6 od high idle");

    // R1 two samples, one read
    sample(DB, 0); sample(DC, 0);
    rdReg(A_ST); push(K_RD, 1, "R1 flag");
    rdReg(A_ST); push(K_RD, 0, "R1 single clear");

    // R10 readback
    rdReg(A_MD); push(K_RD, 8'h03, "R10 mode");
    wrReg(A_EN, 8'hA5); rdReg(A_EN); push(K_RD, 8'hA5, "R10 enable");
    rdReg(4'h9); push(K_RD, 0, "R10 unmapped");

    @(posedge clk); @(posedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule